// File: doc/BRIEF.md
# Two-Port Mailbox with Maskable Interrupts

This block lets two processors, each on its own port, send short messages to each other. Each port owns an inbox of mailbox registers. Only the opposite port can fill them. When a port writes one of its message slots, the data goes into the other port's inbox. The matching flag bit of the receiver is set. If that bit is not masked, the receiver's active-low interrupt line is pulled low.

Each port shares its low address bits between memory and mailbox traffic. An active-low mailbox-select input chooses between them. While that select is high, the access belongs to the memory path, and this block ignores it. While it is low, the address picks a slot, the flag register or the mask register of the port's mailbox space.

A receiver clears a flag in one of two ways. It can read the mailbox, which clears that flag. It can also write ones to its flag register. If a new message arrives for the same flag in the same clock, the flag stays set.

Top module: `dual_mailbox`

## Requirements
- R1: After synchronous reset, every flag is 0, every mask bit is 1, both interrupt outputs are high and both read-data outputs are 0.
- R2: An access with mailbox-select high has no effect: no slot, flag or mask changes, and read data stays 0.
- R3: A write by one port with mailbox-select low at offset i (0 to 3) stores the data in slot i of the other port's inbox and sets that port's flag bit i. A read by the receiver at offset i returns the stored data on read data in the cycle after the read edge.
- R4: Messages travel both ways. A write from port b lands in port a's inbox. A write never changes the writer's own flags.
- R5: A read at offset 4 returns the port's flags in bits 3:0, with upper bits 0. A read of slot i clears flag bit i at the same edge.
- R6: A write at offset 4 clears each flag bit whose data bit is 1 and leaves the bits whose data bit is 0.
- R7: Offset 5 holds the port's mask in bits 3:0, readable and writable, where 1 means masked. The interrupt output is low exactly when some flag bit is 1 and its mask bit is 0. It follows the clock edge that changes a flag or mask.
- R8: When a write from the peer and a clear by the owner hit the same flag in one cycle, the flag ends set.
- R9: Offsets 6 to 63 ignore writes and read as 0. Read data is 0 in any cycle that does not follow a mailbox read.
- R10: When the peer writes slot i in the same cycle the owner reads it, the read returns the old contents and the new data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port a access strobe |
| a_we | input | 1 | Port a write (1) or read (0) |
| a_mbx_sel_n | input | 1 | Port a mailbox select, low selects mailbox space |
| a_addr | input | 6 | Port a low address bits |
| a_wdata | input | 16 | Port a write data |
| a_rdata | output | 16 | Port a registered read data |
| a_irq_n | output | 1 | Port a interrupt, active low |
| b_en | input | 1 | Port b access strobe |
| b_we | input | 1 | Port b write (1) or read (0) |
| b_mbx_sel_n | input | 1 | Port b mailbox select, low selects mailbox space |
| b_addr | input | 6 | Port b low address bits |
| b_wdata | input | 16 | Port b write data |
| b_rdata | output | 16 | Port b registered read data |
| b_irq_n | output | 1 | Port b interrupt, active low |

## Verification
The bench builds the block with its defaults: four slots per port, 16-bit data and a 6-bit address. With these values the flag and mask registers sit at offsets 4 and 5, and every flag bit can be reached. The wide unused range from 6 to 63 can also be probed. The bench drives both ports in the same cycle to exercise the set-over-clear priority and the read-old-data rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BOX_RD,
        ACC_BOX_WR,
        ACC_FLAG_RD,
        ACC_FLAG_CLR,
        ACC_MASK_RD,
        ACC_MASK_WR
    } acc_kind_e;

    // Map one port's bus cycle onto an access kind in mailbox space.
    function automatic acc_kind_e classify(
        input logic        en,
        input logic        we,
        input logic        sel_n,
        input int unsigned offs,
        input int unsigned nbox
    );
        if (!en || sel_n)      return ACC_NONE;
        if (offs < nbox)       return we ? ACC_BOX_WR : ACC_BOX_RD;
        if (offs == nbox)      return we ? ACC_FLAG_CLR : ACC_FLAG_RD;
        if (offs == nbox + 1)  return we ? ACC_MASK_WR : ACC_MASK_RD;
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned NUM_BOX = 4,
    localparam int unsigned IDX_W  = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1
) (
    input  logic              en,
    input  logic              we,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        kind = classify(en, we, sel_n, 32'(addr), NUM_BOX);
        idx  = addr[IDX_W-1:0];
    end

endmodule

// File: rtl/mbx_inbox.sv
module mbx_inbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_BOX = 4,
    localparam int unsigned IDX_W  = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         own_kind,
    input  logic [IDX_W-1:0]  own_idx,
    input  logic [DATA_W-1:0] own_wdata,
    input  acc_kind_e         peer_kind,
    input  logic [IDX_W-1:0]  peer_idx,
    input  logic [DATA_W-1:0] peer_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);

    logic [DATA_W-1:0]  box [NUM_BOX];
    logic [NUM_BOX-1:0] flag;
    logic [NUM_BOX-1:0] mask;
    logic [NUM_BOX-1:0] set_vec;
    logic [NUM_BOX-1:0] clr_vec;

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_slot
        always_comb begin
            set_vec[i] = (peer_kind == ACC_BOX_WR) && (peer_idx == IDX_W'(i));
            clr_vec[i] = ((own_kind == ACC_BOX_RD) && (own_idx == IDX_W'(i)))
                       || ((own_kind == ACC_FLAG_CLR) && own_wdata[i]);
        end

        always_ff @(posedge clk) begin
            if (rst)             box[i] <= '0;
            else if (set_vec[i]) box[i] <= peer_wdata;
        end

        // R3: a peer write lands in the addressed slot
        assert_slot_written_R3: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> (box[i] == $past(peer_wdata)));
    end

    // Set has priority over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) flag <= '0;
        else     flag <= (flag & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst)                         mask <= '1;
        else if (own_kind == ACC_MASK_WR) mask <= own_wdata[NUM_BOX-1:0];
    end

    // Registered read port; old slot contents win over a same-cycle write.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            unique case (own_kind)
                ACC_BOX_RD:  rdata <= box[own_idx];
                ACC_FLAG_RD: rdata <= DATA_W'(flag);
                ACC_MASK_RD: rdata <= DATA_W'(mask);
                default:     rdata <= '0;
            endcase
        end
    end

    assign irq_n = ~|(flag & ~mask);

    // R8: a flag being set ends set, whatever clear hits it
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flag & $past(set_vec)) == $past(set_vec)));

    // R5, R6: cleared bits without a concurrent set end at zero
    assert_clear_done_R6: assert property (@(posedge clk) disable iff (rst)
        (|(clr_vec & ~set_vec)) |=> ((flag & $past(clr_vec & ~set_vec)) == '0));

    // R1: reset leaves every source masked
    assert_mask_reset_R1: assert property (@(posedge clk)
        rst |=> (&mask));

    // R7: mask moves only on a mask write
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (own_kind != ACC_MASK_WR) |=> $stable(mask));

    // R9: no read access means zero read data next cycle
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (own_kind inside {ACC_NONE, ACC_BOX_WR, ACC_FLAG_CLR, ACC_MASK_WR})
        |=> (rdata == '0));

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned NUM_BOX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_mbx_sel_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_mbx_sel_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam int unsigned IDX_W   = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;
    localparam int unsigned N_PORTS = 2;

    // Flag and mask offsets must fit the address and data fields.
    if (NUM_BOX + 2 > (1 << ADDR_W)) begin : g_bad_addr
        $error("mailbox space does not fit the address width");
    end
    if (NUM_BOX > DATA_W) begin : g_bad_data
        $error("flag register wider than data path");
    end

    logic              p_en    [N_PORTS];
    logic              p_we    [N_PORTS];
    logic              p_sel_n [N_PORTS];
    logic [ADDR_W-1:0] p_addr  [N_PORTS];
    logic [DATA_W-1:0] p_wdata [N_PORTS];
    logic [DATA_W-1:0] p_rdata [N_PORTS];
    logic              p_irq_n [N_PORTS];
    acc_kind_e         p_kind  [N_PORTS];
    logic [IDX_W-1:0]  p_idx   [N_PORTS];

    assign p_en[0]    = a_en;
    assign p_we[0]    = a_we;
    assign p_sel_n[0] = a_mbx_sel_n;
    assign p_addr[0]  = a_addr;
    assign p_wdata[0] = a_wdata;
    assign p_en[1]    = b_en;
    assign p_we[1]    = b_we;
    assign p_sel_n[1] = b_mbx_sel_n;
    assign p_addr[1]  = b_addr;
    assign p_wdata[1] = b_wdata;

    assign a_rdata = p_rdata[0];
    assign a_irq_n = p_irq_n[0];
    assign b_rdata = p_rdata[1];
    assign b_irq_n = p_irq_n[1];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        localparam int unsigned PEER = N_PORTS - 1 - p;

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .NUM_BOX (NUM_BOX)
        ) u_dec (
            .en    (p_en[p]),
            .we    (p_we[p]),
            .sel_n (p_sel_n[p]),
            .addr  (p_addr[p]),
            .kind  (p_kind[p]),
            .idx   (p_idx[p])
        );

        mbx_inbox #(
            .DATA_W  (DATA_W),
            .NUM_BOX (NUM_BOX)
        ) u_inbox (
            .clk        (clk),
            .rst        (rst),
            .own_kind   (p_kind[p]),
            .own_idx    (p_idx[p]),
            .own_wdata  (p_wdata[p]),
            .peer_kind  (p_kind[PEER]),
            .peer_idx   (p_idx[PEER]),
            .peer_wdata (p_wdata[PEER]),
            .rdata      (p_rdata[p]),
            .irq_n      (p_irq_n[p])
        );

        // R2: memory-mode cycles never reach the mailbox space
        assert_memmode_quiet_R2: assert property (@(posedge clk) disable iff (rst)
            p_sel_n[p] |-> (p_kind[p] == ACC_NONE));
    end

endmodule

// File: tb/sim_dual_mailbox.sv
module sim_dual_mailbox;

    logic        clk = 1'b0;
    logic        rst;
    logic        a_en, a_we, a_mbx_sel_n, b_en, b_we, b_mbx_sel_n;
    logic [5:0]  a_addr, b_addr;
    logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_irq_n, b_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_mailbox u0 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_mbx_sel_n(a_mbx_sel_n), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_en(b_en), .b_we(b_we), .b_mbx_sel_n(b_mbx_sel_n), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_en = 0; a_we = 0; a_mbx_sel_n = 1; a_addr = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_mbx_sel_n = 1; b_addr = '0; b_wdata = '0;
    endtask

    // One access on one port; returns at the falling edge after the capture edge.
    task automatic op(input bit port_b, input bit we, input bit sel_n,
                      input logic [5:0] addr, input logic [15:0] wd,
                      output logic [15:0] rd);
        @(negedge clk);
        if (port_b) begin
            b_en = 1; b_we = we; b_mbx_sel_n = sel_n; b_addr = addr; b_wdata = wd;
        end else begin
            a_en = 1; a_we = we; a_mbx_sel_n = sel_n; a_addr = addr; a_wdata = wd;
        end
        @(negedge clk);
        idle();
        rd = port_b ? b_rdata : a_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] rd;
        check("R1 a_irq_n", 16'(a_irq_n), 16'h1);
        check("R1 b_irq_n", 16'(b_irq_n), 16'h1);
        check("R1 a_rdata", a_rdata, 16'h0);
        op(0, 0, 0, 6'd5, 0, rd); check("R1 a mask", rd, 16'h000F);
        op(1, 0, 0, 6'd4, 0, rd); check("R1 b flags", rd, 16'h0000);
    endtask

    task automatic t_memmode();
        logic [15:0] rd;
        op(0, 1, 1, 6'd0, 16'hAAAA, rd);
        op(0, 1, 1, 6'd5, 16'h0000, rd);
        op(1, 0, 1, 6'd0, 0, rd); check("R2 read in memory mode", rd, 16'h0);
        op(1, 0, 0, 6'd4, 0, rd); check("R2 no flag", rd, 16'h0);
        op(0, 0, 0, 6'd5, 0, rd); check("R2 mask kept", rd, 16'h000F);
        op(1, 0, 0, 6'd0, 0, rd); check("R2 slot kept", rd, 16'h0);
    endtask

    task automatic t_forward();
        logic [15:0] rd;
        op(0, 1, 0, 6'd2, 16'hBEEF, rd);
        check("R7 masked irq", 16'(b_irq_n), 16'h1);
        op(1, 0, 0, 6'd4, 0, rd); check("R3 b flag set", rd, 16'h0004);
        op(1, 1, 0, 6'd5, 16'h0000, rd);
        check("R7 unmasked irq", 16'(b_irq_n), 16'h0);
        op(1, 0, 0, 6'd2, 0, rd); check("R3 b reads slot", rd, 16'hBEEF);
        check("R5 irq after read", 16'(b_irq_n), 16'h1);
        op(1, 0, 0, 6'd4, 0, rd); check("R5 flag cleared by read", rd, 16'h0);
    endtask

    task automatic t_reverse();
        logic [15:0] rd;
        op(1, 1, 0, 6'd1, 16'h1234, rd);
        op(0, 0, 0, 6'd4, 0, rd); check("R4 a flag set", rd, 16'h0002);
        op(1, 0, 0, 6'd4, 0, rd); check("R4 writer flags untouched", rd, 16'h0);
        op(0, 0, 0, 6'd1, 0, rd); check("R4 a reads slot", rd, 16'h1234);
    endtask

    task automatic t_clear_mask();
        logic [15:0] rd;
        op(1, 1, 0, 6'd0, 16'h0A0A, rd);
        op(1, 1, 0, 6'd3, 16'h3C3C, rd);
        op(0, 0, 0, 6'd4, 0, rd); check("R5 flags read", rd, 16'h0009);
        op(0, 1, 0, 6'd4, 16'h0001, rd);
        op(0, 0, 0, 6'd4, 0, rd); check("R6 write-one clear", rd, 16'h0008);
        op(0, 1, 0, 6'd5, 16'h0007, rd);
        check("R7 bit3 unmasked", 16'(a_irq_n), 16'h0);
        op(0, 1, 0, 6'd5, 16'h000F, rd);
        check("R7 all masked", 16'(a_irq_n), 16'h1);
        op(0, 0, 0, 6'd5, 0, rd); check("R7 mask readback", rd, 16'h000F);
        op(0, 1, 0, 6'd4, 16'h0008, rd);
        op(0, 0, 0, 6'd4, 0, rd); check("R6 cleared", rd, 16'h0);
    endtask

    task automatic t_collide();
        logic [15:0] rd;
        // peer write and owner clear of flag 0 in one cycle
        @(negedge clk);
        b_en = 1; b_we = 1; b_mbx_sel_n = 0; b_addr = 6'd0; b_wdata = 16'h5555;
        a_en = 1; a_we = 1; a_mbx_sel_n = 0; a_addr = 6'd4; a_wdata = 16'h0001;
        @(negedge clk); idle();
        op(0, 0, 0, 6'd4, 0, rd); check("R8 set beats write clear", rd, 16'h0001);
        op(0, 0, 0, 6'd0, 0, rd);
        op(1, 1, 0, 6'd2, 16'h1111, rd);
        op(0, 0, 0, 6'd2, 0, rd);
        // peer write and owner read of slot 2 in one cycle
        @(negedge clk);
        b_en = 1; b_we = 1; b_mbx_sel_n = 0; b_addr = 6'd2; b_wdata = 16'h2222;
        a_en = 1; a_we = 0; a_mbx_sel_n = 0; a_addr = 6'd2;
        @(negedge clk); idle();
        check("R10 old data read", a_rdata, 16'h1111);
        op(0, 0, 0, 6'd4, 0, rd); check("R8 set beats read clear", rd, 16'h0004);
        op(0, 0, 0, 6'd2, 0, rd); check("R10 new data kept", rd, 16'h2222);
    endtask

    task automatic t_unused();
        logic [15:0] rd;
        op(0, 1, 0, 6'd6, 16'hFFFF, rd);
        op(0, 1, 0, 6'd63, 16'hFFFF, rd);
        op(1, 0, 0, 6'd4, 0, rd); check("R9 no flag from unused", rd, 16'h0);
        op(0, 0, 0, 6'd40, 0, rd); check("R9 unused reads zero", rd, 16'h0);
        op(0, 0, 0, 6'd5, 0, rd); check("R9 mask untouched", rd, 16'h000F);
        @(negedge clk); check("R9 idle read data", a_rdata, 16'h0);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_memmode();
        t_forward();
        t_reverse();
        t_clear_mask();
        t_collide();
        t_unused();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule